// File: doc/BRIEF.md
# Power-of-Two Shift-Accumulate Vector Unit

This unit forms dot products between a vector of signed 8-bit activations and a vector of 4-bit power-of-two weights. It builds every lane product from barrel shifts and adds, with no multiplier. It sums the lane products and adds the total into a signed 32-bit accumulator. A quasi-static mode input chooses how each 4-bit weight is read. The choices are a single signed power-of-two, a two-term additive code or a two-term mixed code. Each two-term code gives its bits to its two terms in a different way, and in both codes either term can be zero.

One activation vector and one packed weight vector enter on each cycle that `in_valid_i` is high. The data passes through two register stages: lane decode and shift, then the adder tree and the accumulate. The accumulator value comes out with `out_valid_o` two cycles after the beat. To start a new dot product, raise `clear_i` on its first beat. That beat then adds onto zero and does not add onto the old total.

Top module: `pot_vsu`

## Requirements
- R1: While `rst_n` is low, `acc_o` is 0 and `out_valid_o` is 0.
- R2: A beat accepted at a rising edge (`in_valid_i` high) raises `out_valid_o` for exactly one cycle, starting at the second rising edge after it. Back-to-back beats give back-to-back results, and no result appears without a beat.
- R3: Each beat adds the signed sum of its eight lane products to the accumulator, and `acc_o` shows the new total. The total wraps modulo 2^32 on overflow.
- R4: A beat with `clear_i` high adds its dot product onto zero instead of the previous total. `clear_i` has no effect on cycles without a valid beat.
- R5: Mode 0 (single term) reads weight bit 3 as the sign (1 means negative) and bits 2:0 as a shift s. The weight value is ±2^s, so zero cannot be expressed.
- R6: Mode 1 (additive) reads bit 3 as the sign. Bits 2:1 give a first term of 0, 4, 8 or 16 for codes 0 to 3, and bit 0 gives a second term of 0 or 1. The weight value is ±(first + second).
- R7: Mode 2 (mixed) reads bit 3 as the sign. Bit 2 gives a first term of 0 or 8, and bits 1:0 give a second term of 0, 1, 2 or 4 for codes 0 to 3. The weight value is ±(first + second).
- R8: In modes 1 and 2, a zero term adds nothing. A weight whose two terms are both zero yields a product of 0 for any activation and either sign bit.
- R9: Mode 3 makes every lane product 0, so an accepted beat leaves the total unchanged, or sets it to 0 if `clear_i` is high.
- R10: Lane i takes its activation from `act_i[8i+7:8i]` and its weight from `wgt_i[4i+3:4i]`, for i from 0 to 7.
- R11: While no result is being delivered, `acc_o` holds its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Weight encoding select, held steady while beats are in flight |
| in_valid_i | input | 1 | Beat present on `act_i`/`wgt_i` |
| clear_i | input | 1 | Start a new total with this beat |
| act_i | input | 64 | Eight packed signed 8-bit activations |
| wgt_i | input | 32 | Eight packed 4-bit weights |
| out_valid_o | output | 1 | `acc_o` holds a freshly updated total |
| acc_o | output | 32 | Signed accumulator |

## Verification
A wrong shift amount or a wrong term-enable in one encoding shows up at the very next result as a total that differs from the value built from decoded integer weights. The one-hot lane tests and the all-zero-term tests narrow the cause to one lane or one term. A slip in the valid pipeline or in the clear handling shows within two cycles, as a missing or extra `out_valid_o` pulse or a total that keeps its old value. A corrupted accumulator stays wrong, because every later result builds on it. The long run across the 32-bit wrap exposes a carry or sign-extension fault once the total crosses the boundary.

// File: rtl/pot_vsu_pkg.sv
package pot_vsu_pkg;

    localparam int WGT_W = 4;

    typedef enum logic [1:0] {
        MODE_SINGLE = 2'd0,
        MODE_ADD    = 2'd1,
        MODE_MIX    = 2'd2,
        MODE_OFF    = 2'd3
    } wmode_e;

    // Two shift terms plus a sign, decoded from one weight nibble.
    typedef struct packed {
        logic       en_a;
        logic [2:0] sh_a;
        logic       en_b;
        logic [2:0] sh_b;
        logic       neg;
    } term_t;

    function automatic term_t decode_weight(input wmode_e mode, input logic [WGT_W-1:0] w);
        term_t t;
        t = '0;
        t.neg = w[3];
        case (mode)
            MODE_SINGLE: begin
                t.en_a = 1'b1;
                t.sh_a = w[2:0];
            end
            MODE_ADD: begin
                // first term 4/8/16, second term 1
                t.en_a = (w[2:1] != 2'b00);
                t.sh_a = {1'b0, w[2:1]} + 3'd1;
                t.en_b = w[0];
                t.sh_b = 3'd0;
            end
            MODE_MIX: begin
                // first term 8, second term 1/2/4
                t.en_a = w[2];
                t.sh_a = 3'd3;
                t.en_b = (w[1:0] != 2'b00);
                t.sh_b = {1'b0, w[1:0]} - 3'd1;
            end
            default: t = '0;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/pot_vsu_lane.sv
module pot_vsu_lane
    import pot_vsu_pkg::*;
#(
    parameter int ACT_W  = 8,
    parameter int PROD_W = 16
) (
    input  wmode_e                    mode,
    input  logic [ACT_W-1:0]          act,
    input  logic [WGT_W-1:0]          wgt,
    output logic signed [PROD_W-1:0]  prod
);

    term_t                     t;
    logic signed [PROD_W-1:0]  ax;
    logic signed [PROD_W-1:0]  part_a;
    logic signed [PROD_W-1:0]  part_b;
    logic signed [PROD_W-1:0]  mag;

    always_comb begin
        t      = decode_weight(mode, wgt);
        ax     = {{(PROD_W-ACT_W){act[ACT_W-1]}}, act};
        part_a = t.en_a ? (ax <<< t.sh_a) : '0;
        part_b = t.en_b ? (ax <<< t.sh_b) : '0;
        mag    = part_a + part_b;
        prod   = t.neg ? -mag : mag;
    end

endmodule

// File: rtl/pot_vsu_sum.sv
module pot_vsu_sum #(
    parameter int LANES  = 8,
    parameter int PROD_W = 16,
    parameter int SUM_W  = 19
) (
    input  logic [LANES*PROD_W-1:0]  prods,
    output logic signed [SUM_W-1:0]  sum
);

    always_comb begin
        sum = '0;
        for (int i = 0; i < LANES; i++) begin
            sum = sum + SUM_W'($signed(prods[i*PROD_W +: PROD_W]));
        end
    end

endmodule

// File: rtl/pot_vsu.sv
module pot_vsu
    import pot_vsu_pkg::*;
#(
    parameter int LANES = 8,
    parameter int ACT_W = 8,
    parameter int ACC_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               mode_i,
    input  logic                     in_valid_i,
    input  logic                     clear_i,
    input  logic [LANES*ACT_W-1:0]   act_i,
    input  logic [LANES*WGT_W-1:0]   wgt_i,
    output logic                     out_valid_o,
    output logic [ACC_W-1:0]         acc_o
);

    localparam int MAX_SH = (1 << 3) - 1;
    localparam int PROD_W = ACT_W + MAX_SH + 1;
    localparam int SUM_W  = PROD_W + $clog2(LANES);

    typedef struct packed {
        logic                      s1_valid;
        logic                      s1_clear;
        logic [LANES*PROD_W-1:0]   s1_prod;
        logic                      out_valid;
        logic [ACC_W-1:0]          acc;
    } state_t;

    state_t                    st_d, st_q;
    wmode_e                    mode;
    logic [LANES*PROD_W-1:0]   lane_prod;
    logic signed [SUM_W-1:0]   tree_sum;

    assign mode = wmode_e'(mode_i);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic signed [PROD_W-1:0] p;
        pot_vsu_lane #(.ACT_W(ACT_W), .PROD_W(PROD_W)) lane_i (
            .mode (mode),
            .act  (act_i[g*ACT_W +: ACT_W]),
            .wgt  (wgt_i[g*WGT_W +: WGT_W]),
            .prod (p)
        );
        assign lane_prod[g*PROD_W +: PROD_W] = p;
    end

    pot_vsu_sum #(.LANES(LANES), .PROD_W(PROD_W), .SUM_W(SUM_W)) sum_i (
        .prods (st_q.s1_prod),
        .sum   (tree_sum)
    );

    always_comb begin
        st_d          = st_q;
        st_d.s1_valid = in_valid_i;
        st_d.s1_clear = in_valid_i & clear_i;
        if (in_valid_i) begin
            st_d.s1_prod = lane_prod;
        end
        st_d.out_valid = st_q.s1_valid;
        if (st_q.s1_valid) begin
            st_d.acc = (st_q.s1_clear ? '0 : st_q.acc)
                     + {{(ACC_W-SUM_W){tree_sum[SUM_W-1]}}, tree_sum};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid_o = st_q.out_valid;
    assign acc_o       = st_q.acc;

endmodule

// File: rtl/pot_vsu_chk.sv
module pot_vsu_chk #(
    parameter int ACC_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        mode_i,
    input logic              in_valid_i,
    input logic              clear_i,
    input logic              out_valid_o,
    input logic [ACC_W-1:0]  acc_o
);

    logic [1:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst <= 2'd0;
        end else if (since_rst != 2'd2) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |-> (acc_o == '0 && !out_valid_o));

    // R2
    result_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd2) |-> (out_valid_o == $past(in_valid_i, 2)));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != 2'd0 && !out_valid_o) |-> $stable(acc_o));

    // R9
    off_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd2 && out_valid_o && $past(mode_i, 2) == 2'd3)
        |-> (acc_o == ($past(clear_i, 2) ? '0 : $past(acc_o))));

endmodule

bind pot_vsu pot_vsu_chk #(.ACC_W(ACC_W)) chk_i (.*);

// File: tb/pot_vsu_tb_top.sv
module pot_vsu_tb_top;

    localparam int LANES = 8;
    localparam int ACT_W = 8;
    localparam int WGT_W = 4;
    localparam int ACC_W = 32;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic [1:0]              mode_i = 2'd0;
    logic                    in_valid_i = 1'b0;
    logic                    clear_i = 1'b0;
    logic [LANES*ACT_W-1:0]  act_i = '0;
    logic [LANES*WGT_W-1:0]  wgt_i = '0;
    logic                    out_valid_o;
    logic [ACC_W-1:0]        acc_o;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    logic signed [ACC_W-1:0] model = '0;
    logic [ACC_W-1:0] exp_q[$];
    int               cyc_q[$];
    string            tag_q[$];

    always #10 clk = ~clk;

    pot_vsu dut_i (.*);

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int wval(input logic [1:0] m, input logic [3:0] w);
        int mag;
        case (m)
            2'd0: mag = 1 << w[2:0];
            2'd1: mag = ((w[2:1] == 2'd0) ? 0 : (2 << w[2:1])) + int'(w[0]);
            2'd2: mag = (w[2] ? 8 : 0) + ((w[1:0] == 2'd0) ? 0 : (1 << (w[1:0] - 2'd1)));
            default: mag = 0;
        endcase
        return w[3] ? -mag : mag;
    endfunction

    function automatic int dot(input logic [1:0] m, input logic [LANES*ACT_W-1:0] a,
                               input logic [LANES*WGT_W-1:0] w);
        int s = 0;
        for (int i = 0; i < LANES; i++)
            s += int'($signed(a[i*ACT_W +: ACT_W])) * wval(m, w[i*WGT_W +: WGT_W]);
        return s;
    endfunction

    task automatic check(input string tag, input logic [ACC_W-1:0] act, input logic [ACC_W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, $signed(act), $signed(exp));
        end
    endtask

    // Result checker at the falling edge: R2 timing and R3 value.
    always @(negedge clk) begin
        if (rst_n && out_valid_o) begin
            if (exp_q.size() == 0) begin
                check("R2 unexpected out_valid", 32'd1, 32'd0);
            end else begin
                check({tag_q[0], " R2 latency"}, cyc, cyc_q[0] + 2);
                check(tag_q[0], acc_o, exp_q[0]);
                void'(exp_q.pop_front());
                void'(cyc_q.pop_front());
                void'(tag_q.pop_front());
            end
        end
    end

    task automatic beat(input logic [LANES*ACT_W-1:0] a, input logic [LANES*WGT_W-1:0] w,
                        input logic clr, input string tag);
        @(negedge clk);
        in_valid_i = 1'b1;
        clear_i    = clr;
        act_i      = a;
        wgt_i      = w;
        model      = (clr ? 32'sd0 : model) + ACC_W'(dot(mode_i, a, w));
        exp_q.push_back(model);
        cyc_q.push_back(cyc);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid_i = 1'b0;
            clear_i    = 1'b0;
            act_i      = {LANES{8'h5A}};
            wgt_i      = {LANES{4'h7}};
        end
    endtask

    task automatic rnd_burst(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            logic [LANES*ACT_W-1:0] a;
            logic [LANES*WGT_W-1:0] w;
            a = {$urandom, $urandom};
            w = $urandom;
            beat(a, w, (i == 0), tag);
        end
        idle(3);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check("watchdog", 32'd1, 32'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        #1;
        check("R1 acc at reset", acc_o, 32'd0);
        check("R1 valid at reset", {31'd0, out_valid_o}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        // R5: all sixteen single-term codes over two beats
        mode_i = 2'd0;
        beat({8'sd3, -8'sd5, 8'sd7, 8'sd1, -8'sd128, 8'sd127, 8'sd2, -8'sd1},
             32'h76543210, 1'b1, "R5");
        beat({8'sd3, -8'sd5, 8'sd7, 8'sd1, -8'sd128, 8'sd127, 8'sd2, -8'sd1},
             32'hFEDCBA98, 1'b0, "R5");
        idle(3);

        // R6: additive codes
        mode_i = 2'd1;
        beat({8'sd9, -8'sd7, 8'sd100, 8'sd1, -8'sd128, 8'sd127, 8'sd2, -8'sd3},
             32'h76543210, 1'b1, "R6");
        beat({8'sd9, -8'sd7, 8'sd100, 8'sd1, -8'sd128, 8'sd127, 8'sd2, -8'sd3},
             32'hFEDCBA98, 1'b0, "R6");
        idle(3);
        // R8: additive zero terms, both signs
        beat({LANES{-8'sd128}}, {4{8'h08}}, 1'b1, "R8 additive zero");
        idle(3);

        // R7: mixed codes
        mode_i = 2'd2;
        beat({8'sd11, -8'sd7, 8'sd100, 8'sd1, -8'sd128, 8'sd127, 8'sd2, -8'sd3},
             32'h76543210, 1'b1, "R7");
        beat({8'sd11, -8'sd7, 8'sd100, 8'sd1, -8'sd128, 8'sd127, 8'sd2, -8'sd3},
             32'hFEDCBA98, 1'b0, "R7");
        idle(3);
        beat({LANES{8'sd127}}, {4{8'h80}}, 1'b1, "R8 mixed zero");
        idle(3);

        // R10: one lane at a time, single-term shift equal to lane index
        mode_i = 2'd0;
        for (int i = 0; i < LANES; i++) begin
            logic [LANES*ACT_W-1:0] a;
            logic [LANES*WGT_W-1:0] w;
            a = '0;
            w = '0;
            a[i*ACT_W +: ACT_W] = 8'd1;
            w[i*WGT_W +: WGT_W] = 4'(i);
            beat(a, w, 1'b1, "R10 lane");
        end
        idle(3);

        // R9: off mode keeps the total, clear zeroes it
        rnd_burst(4, "R3 pre-off");
        model = model;
        mode_i = 2'd3;
        beat({LANES{8'sd50}}, {LANES{4'h3}}, 1'b0, "R9 hold");
        beat({LANES{8'sd50}}, {LANES{4'h3}}, 1'b1, "R9 clear");
        idle(3);

        // R3 random accumulation in every active mode
        for (int m = 0; m < 3; m++) begin
            mode_i = 2'(m);
            rnd_burst(60, "R3 random");
        end

        // R11 and R4: idle cycles with clear toggling change nothing
        mode_i = 2'd2;
        rnd_burst(5, "R3 before idle");
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            clear_i = 1'b1;
            check("R11 hold / R4 clear without beat", acc_o, model);
            check("R11 no valid", {31'd0, out_valid_o}, 32'd0);
        end
        clear_i = 1'b0;
        // R4: clear in the middle of a stream
        beat({LANES{8'sd10}}, {LANES{4'h5}}, 1'b0, "R4 before");
        beat({LANES{8'sd3}}, {LANES{4'h1}}, 1'b1, "R4 clear mid");
        beat({LANES{8'sd3}}, {LANES{4'h1}}, 1'b0, "R4 after");
        idle(3);

        // R3 wrap: -131072 per beat crosses -2^31
        mode_i = 2'd0;
        for (int i = 0; i < 16390; i++)
            beat({LANES{-8'sd128}}, {LANES{4'h7}}, (i == 0), "R3 wrap");
        idle(4);
        check("R3 wrap final", acc_o, model);
        check("R2 queue drained", exp_q.size(), 32'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule